// File: doc/BRIEF.md
# Single-Cycle Stack Machine Core

This block is a small processor core that completes one whole instruction on every clock edge. In a single cycle it reads the instruction bytes at the program counter, reads its operands from eight 32-bit registers, computes a result, may read or write a 32-bit word of an internal byte-addressed memory, writes up to two registers, and picks the next program counter. Register 4 serves as the stack pointer. Push, pop, call and return use it implicitly. Three condition flags (zero, sign, overflow) record the outcome of the last arithmetic or logic instruction. Conditional jumps and conditional moves test these flags.

The memory is loaded byte by byte through a load port while reset is held. Once reset is released the core runs until a status register leaves the running code. From then on the core is frozen. A peek port returns any register's value so that the surrounding logic can observe results.

Instruction byte 0 holds the opcode in its high nibble and the function in its low nibble. An optional register byte follows, with the A register in the high nibble and the B register in the low nibble. A register nibble of F means "no register": it reads as 0 and is never written. Constants are 4 bytes, least significant byte first. The opcodes and their lengths are:

- 0 halt (1 byte)
- 1 nop (1 byte)
- 2 register move or conditional move (2 bytes)
- 3 immediate load (6 bytes)
- 4 store (6 bytes)
- 5 load (6 bytes)
- 6 arithmetic/logic (2 bytes)
- 7 jump (5 bytes)
- 8 call (5 bytes)
- 9 return (1 byte)
- A push (2 bytes)
- B pop (2 bytes)

Top module: `seqcore`

## Requirements
- R1: While reset is high, and on the cycle after it, the core shows PC 0, status 1 (running), all eight registers 0 and all flags 0.
- R2: Each rising clock edge outside reset retires exactly one instruction. The PC advances by the instruction's length, following the opcode/length list above.
- R3: Opcode 6 computes B := B op A, with function 0 add, 1 subtract (B minus A), 2 and, 3 xor. It sets zero when the result is 0 and sign from bit 31. It sets overflow on signed overflow of add or subtract, and clears it for and/xor. The flags port is {zero, sign, overflow}.
- R4: Store (opcode 4) writes register A to address reg[B] + displacement. Load (opcode 5) reads address reg[B] + displacement into register A. Every transfer is 4 bytes, little endian.
- R5: Push (A0, rA F) lowers the stack pointer by 4 and stores register A at the new stack pointer. Pop (B0, rA F) loads register A from the old stack pointer and raises the stack pointer by 4. A pop into register 4 leaves the loaded value in register 4.
- R6: Call (80, target) stores the address after the call at stack pointer − 4, lowers the stack pointer by 4 and jumps to the target. Return (90) jumps to the word at the stack pointer and raises the stack pointer by 4.
- R7: Opcode 7 jumps to its target when its condition holds and falls through otherwise. The conditions by function are: 0 always, 1 less-or-equal ((S^O)|Z), 2 less (S^O), 3 equal (Z), 4 not equal (!Z), 5 greater-or-equal (!(S^O)), 6 greater (!(S^O)&!Z).
- R8: Opcode 2 with function 0 copies register A to register B. Functions 1 to 6 copy only when the condition of R7 holds, and leave register B unchanged otherwise.
- R9: Halt (byte 00) sets status 2. Whenever status is not 1, the PC, status, flags, registers and memory stay unchanged on every later cycle, and the PC keeps the address of the stopping instruction.
- R10: An unknown opcode (C to F), or a function code outside the range of its opcode, sets status 4 and makes no register, flag, memory or PC update.
- R11: An instruction that makes a fetch or a data access extending beyond the last memory byte sets status 3 and makes no register, flag, memory or PC update. A word at the last four bytes is still accessible.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; memory loading happens while it is high |
| load_en | input | 1 | Writes load_byte into memory at load_addr |
| load_addr | input | MAW (8) | Byte address for loading |
| load_byte | input | 8 | Byte to load |
| peek_sel | input | 3 | Register index for the peek port |
| peek_val | output | 32 | Current value of the selected register |
| pc | output | 32 | Program counter |
| status | output | 3 | 1 running, 2 halted, 3 bad address, 4 bad instruction |
| flags | output | 3 | {zero, sign, overflow} |

## Verification
Every instruction's effects land on the first rising edge after it is fetched. The bench therefore checks the PC and the stack pointer at the falling edge after exactly one, two or three edges from the reset release: PC 6, then 0x0C, and a stack pointer lowered by 4 after the third edge. For whole programs it waits at falling edges until status leaves 1, and only then reads registers through the peek port and compares the flags, PC and status. At that point nothing can still change. A few further cycles are then run to confirm that the halted or faulted state stays frozen.

// File: rtl/seqcore_pkg.sv
package seqcore_pkg;

    localparam int XLEN     = 32;
    localparam int NREG     = 8;
    localparam int FETCH_W  = 6;
    localparam int WORD_B   = XLEN / 8;

    localparam logic [3:0] REG_NONE = 4'hF;
    localparam logic [3:0] REG_SP   = 4'd4;

    localparam logic [3:0] OP_HALT  = 4'h0;
    localparam logic [3:0] OP_NOP   = 4'h1;
    localparam logic [3:0] OP_MOVRR = 4'h2;
    localparam logic [3:0] OP_MOVIR = 4'h3;
    localparam logic [3:0] OP_STORE = 4'h4;
    localparam logic [3:0] OP_LOAD  = 4'h5;
    localparam logic [3:0] OP_ALU   = 4'h6;
    localparam logic [3:0] OP_JUMP  = 4'h7;
    localparam logic [3:0] OP_CALL  = 4'h8;
    localparam logic [3:0] OP_RET   = 4'h9;
    localparam logic [3:0] OP_PUSH  = 4'hA;
    localparam logic [3:0] OP_POP   = 4'hB;

    typedef enum logic [2:0] {
        ST_RUN     = 3'd1,
        ST_HALT    = 3'd2,
        ST_BADADDR = 3'd3,
        ST_BADOP   = 3'd4
    } status_e;

    typedef enum logic [1:0] {
        ASEL_VALA,
        ASEL_VALC,
        ASEL_MINUS4,
        ASEL_PLUS4
    } asel_e;

    typedef struct packed {
        logic z;
        logic s;
        logic o;
    } flags_t;

    typedef struct packed {
        logic [XLEN-1:0] val;
        flags_t          f;
    } alu_out_t;

    typedef struct packed {
        logic       valid;
        logic [2:0] len;
        logic       regbyte;
        logic [3:0] src_a;
        logic [3:0] src_b;
        logic [3:0] dst_e;
        logic [3:0] dst_m;
        asel_e      asel;
        logic       b_zero;
        logic [1:0] alu_fn;
        logic       set_cc;
        logic       mem_rd;
        logic       mem_wr;
        logic       addr_from_a;
        logic       wdata_valp;
    } ctrl_t;

    function automatic alu_out_t alu_calc(input logic [1:0] fn,
                                          input logic [XLEN-1:0] a,
                                          input logic [XLEN-1:0] b);
        alu_out_t r;
        case (fn)
            2'd0:    r.val = b + a;
            2'd1:    r.val = b - a;
            2'd2:    r.val = b & a;
            default: r.val = b ^ a;
        endcase
        r.f.z = (r.val == '0);
        r.f.s = r.val[XLEN-1];
        case (fn)
            2'd0:    r.f.o = (a[XLEN-1] == b[XLEN-1]) && (r.val[XLEN-1] != b[XLEN-1]);
            2'd1:    r.f.o = (a[XLEN-1] != b[XLEN-1]) && (r.val[XLEN-1] != b[XLEN-1]);
            default: r.f.o = 1'b0;
        endcase
        return r;
    endfunction

    function automatic logic cond_met(input logic [3:0] fn, input flags_t f);
        logic lt;
        lt = f.s ^ f.o;
        case (fn)
            4'd0:    return 1'b1;
            4'd1:    return lt | f.z;
            4'd2:    return lt;
            4'd3:    return f.z;
            4'd4:    return !f.z;
            4'd5:    return !lt;
            4'd6:    return !lt && !f.z;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/seqcore_decode.sv
module seqcore_decode
    import seqcore_pkg::*;
(
    input  logic [3:0] icode,
    input  logic [3:0] fn,
    input  logic [3:0] ra,
    input  logic [3:0] rb,
    output ctrl_t      ctl
);

    always_comb begin
        ctl         = '0;
        ctl.valid   = 1'b1;
        ctl.len     = 3'd1;
        ctl.src_a   = REG_NONE;
        ctl.src_b   = REG_NONE;
        ctl.dst_e   = REG_NONE;
        ctl.dst_m   = REG_NONE;
        ctl.asel    = ASEL_VALA;
        case (icode)
            OP_HALT, OP_NOP: begin
                ctl.valid = (fn == 4'd0);
            end
            OP_MOVRR: begin
                ctl.valid   = (fn <= 4'd6);
                ctl.len     = 3'd2;
                ctl.regbyte = 1'b1;
                ctl.src_a   = ra;
                ctl.dst_e   = rb;
                ctl.b_zero  = 1'b1;
            end
            OP_MOVIR: begin
                ctl.valid   = (fn == 4'd0);
                ctl.len     = 3'd6;
                ctl.regbyte = 1'b1;
                ctl.dst_e   = rb;
                ctl.asel    = ASEL_VALC;
                ctl.b_zero  = 1'b1;
            end
            OP_STORE: begin
                ctl.valid   = (fn == 4'd0);
                ctl.len     = 3'd6;
                ctl.regbyte = 1'b1;
                ctl.src_a   = ra;
                ctl.src_b   = rb;
                ctl.asel    = ASEL_VALC;
                ctl.mem_wr  = 1'b1;
            end
            OP_LOAD: begin
                ctl.valid   = (fn == 4'd0);
                ctl.len     = 3'd6;
                ctl.regbyte = 1'b1;
                ctl.src_b   = rb;
                ctl.dst_m   = ra;
                ctl.asel    = ASEL_VALC;
                ctl.mem_rd  = 1'b1;
            end
            OP_ALU: begin
                ctl.valid   = (fn <= 4'd3);
                ctl.len     = 3'd2;
                ctl.regbyte = 1'b1;
                ctl.src_a   = ra;
                ctl.src_b   = rb;
                ctl.dst_e   = rb;
                ctl.alu_fn  = fn[1:0];
                ctl.set_cc  = 1'b1;
            end
            OP_JUMP: begin
                ctl.valid   = (fn <= 4'd6);
                ctl.len     = 3'd5;
            end
            OP_CALL: begin
                ctl.valid      = (fn == 4'd0);
                ctl.len        = 3'd5;
                ctl.src_b      = REG_SP;
                ctl.dst_e      = REG_SP;
                ctl.asel       = ASEL_MINUS4;
                ctl.mem_wr     = 1'b1;
                ctl.wdata_valp = 1'b1;
            end
            OP_RET: begin
                ctl.valid       = (fn == 4'd0);
                ctl.src_a       = REG_SP;
                ctl.src_b       = REG_SP;
                ctl.dst_e       = REG_SP;
                ctl.asel        = ASEL_PLUS4;
                ctl.mem_rd      = 1'b1;
                ctl.addr_from_a = 1'b1;
            end
            OP_PUSH: begin
                ctl.valid   = (fn == 4'd0);
                ctl.len     = 3'd2;
                ctl.regbyte = 1'b1;
                ctl.src_a   = ra;
                ctl.src_b   = REG_SP;
                ctl.dst_e   = REG_SP;
                ctl.asel    = ASEL_MINUS4;
                ctl.mem_wr  = 1'b1;
            end
            OP_POP: begin
                ctl.valid       = (fn == 4'd0);
                ctl.len         = 3'd2;
                ctl.regbyte     = 1'b1;
                ctl.src_a       = REG_SP;
                ctl.src_b       = REG_SP;
                ctl.dst_e       = REG_SP;
                ctl.dst_m       = ra;
                ctl.asel        = ASEL_PLUS4;
                ctl.mem_rd      = 1'b1;
                ctl.addr_from_a = 1'b1;
            end
            default: begin
                ctl.valid = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/seqcore_regfile.sv
module seqcore_regfile
    import seqcore_pkg::*;
#(
    parameter int N = NREG,
    parameter int W = XLEN
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [3:0]   rd_a_idx,
    input  logic [3:0]   rd_b_idx,
    output logic [W-1:0] rd_a_val,
    output logic [W-1:0] rd_b_val,
    input  logic         we_e,
    input  logic [3:0]   dst_e,
    input  logic [W-1:0] val_e,
    input  logic         we_m,
    input  logic [3:0]   dst_m,
    input  logic [W-1:0] val_m,
    input  logic [2:0]   peek_idx,
    output logic [W-1:0] peek_val,
    output logic [W-1:0] sp_val
);

    logic [W-1:0] regs [N];

    function automatic logic in_range(input logic [3:0] idx);
        return 32'(idx) < N;
    endfunction

    assign rd_a_val = in_range(rd_a_idx) ? regs[rd_a_idx[2:0]] : '0;
    assign rd_b_val = in_range(rd_b_idx) ? regs[rd_b_idx[2:0]] : '0;
    assign peek_val = regs[peek_idx];
    assign sp_val   = regs[REG_SP[2:0]];

    // The memory-side write comes last so that it wins on a shared index.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                regs[i] <= '0;
            end
        end else begin
            if (we_e && in_range(dst_e)) begin
                regs[dst_e[2:0]] <= val_e;
            end
            if (we_m && in_range(dst_m)) begin
                regs[dst_m[2:0]] <= val_m;
            end
        end
    end

    assert_pop_sp_wins_R5: assert property (@(posedge clk) disable iff (rst)
        (!rst && we_m && dst_m == REG_SP) |=> (sp_val == $past(val_m)));

endmodule

// File: rtl/seqcore_mem.sv
module seqcore_mem
    import seqcore_pkg::*;
#(
    parameter int BYTES = 256,
    localparam int AW   = $clog2(BYTES)
) (
    input  logic                  clk,
    input  logic                  ld_en,
    input  logic [AW-1:0]         ld_addr,
    input  logic [7:0]            ld_byte,
    input  logic [XLEN-1:0]       fetch_addr,
    output logic [8*FETCH_W-1:0]  fetch_win,
    input  logic [XLEN-1:0]       rd_addr,
    output logic [XLEN-1:0]       rd_word,
    input  logic                  wr_en,
    input  logic [XLEN-1:0]       wr_addr,
    input  logic [XLEN-1:0]       wr_word
);

    logic [7:0] bytes_q [BYTES];

    for (genvar k = 0; k < FETCH_W; k++) begin : g_fetch
        assign fetch_win[8*k +: 8] = bytes_q[AW'(fetch_addr + XLEN'(k))];
    end

    for (genvar k = 0; k < WORD_B; k++) begin : g_read
        assign rd_word[8*k +: 8] = bytes_q[AW'(rd_addr + XLEN'(k))];
    end

    always_ff @(posedge clk) begin
        if (ld_en) begin
            bytes_q[ld_addr] <= ld_byte;
        end else if (wr_en) begin
            for (int k = 0; k < WORD_B; k++) begin
                bytes_q[AW'(wr_addr + XLEN'(k))] <= wr_word[8*k +: 8];
            end
        end
    end

endmodule

// File: rtl/seqcore.sv
module seqcore
    import seqcore_pkg::*;
#(
    parameter int MEM_BYTES = 256,
    localparam int MAW      = $clog2(MEM_BYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_en,
    input  logic [MAW-1:0]   load_addr,
    input  logic [7:0]       load_byte,
    input  logic [2:0]       peek_sel,
    output logic [XLEN-1:0]  peek_val,
    output logic [XLEN-1:0]  pc,
    output logic [2:0]       status,
    output logic [2:0]       flags
);

    logic [XLEN-1:0]      pc_q;
    status_e              st_q;
    flags_t               cc_q;

    logic [8*FETCH_W-1:0] fwin;
    logic [3:0]           icode, fn, ra, rb;
    ctrl_t                ctl;
    logic [XLEN-1:0]      valc, valp, vala, valb, valm, sp_val;
    logic [XLEN-1:0]      alu_a, alu_b, mem_addr, wdata, npc;
    alu_out_t             alu;
    logic                 cnd, fetch_bad, data_bad, running, commit;
    status_e              next_st;

    assign icode = fwin[7:4];
    assign fn    = fwin[3:0];
    assign ra    = fwin[15:12];
    assign rb    = fwin[11:8];

    seqcore_decode u_dec (
        .icode (icode),
        .fn    (fn),
        .ra    (ra),
        .rb    (rb),
        .ctl   (ctl)
    );

    assign valc = ctl.regbyte ? fwin[47:16] : fwin[39:8];
    assign valp = pc_q + XLEN'(ctl.len);

    always_comb begin
        case (ctl.asel)
            ASEL_VALA:   alu_a = vala;
            ASEL_VALC:   alu_a = valc;
            ASEL_MINUS4: alu_a = -XLEN'(WORD_B);
            default:     alu_a = XLEN'(WORD_B);
        endcase
    end
    assign alu_b    = ctl.b_zero ? '0 : valb;
    assign alu      = alu_calc(ctl.alu_fn, alu_a, alu_b);
    assign cnd      = cond_met(fn, cc_q);
    assign mem_addr = ctl.addr_from_a ? vala : alu.val;
    assign wdata    = ctl.wdata_valp ? valp : vala;

    assign fetch_bad = ({1'b0, pc_q} + (XLEN+1)'(ctl.len)) > (XLEN+1)'(MEM_BYTES);
    assign data_bad  = (ctl.mem_rd || ctl.mem_wr) &&
                       (({1'b0, mem_addr} + (XLEN+1)'(WORD_B)) > (XLEN+1)'(MEM_BYTES));

    always_comb begin
        if (fetch_bad)            next_st = ST_BADADDR;
        else if (!ctl.valid)      next_st = ST_BADOP;
        else if (data_bad)        next_st = ST_BADADDR;
        else if (icode == OP_HALT) next_st = ST_HALT;
        else                      next_st = ST_RUN;
    end

    assign running = !rst && (st_q == ST_RUN);
    assign commit  = running && (next_st == ST_RUN);

    always_comb begin
        case (icode)
            OP_CALL: npc = valc;
            OP_JUMP: npc = cnd ? valc : valp;
            OP_RET:  npc = valm;
            default: npc = valp;
        endcase
    end

    seqcore_regfile u_rf (
        .clk      (clk),
        .rst      (rst),
        .rd_a_idx (ctl.src_a),
        .rd_b_idx (ctl.src_b),
        .rd_a_val (vala),
        .rd_b_val (valb),
        .we_e     (commit && (icode != OP_MOVRR || cnd)),
        .dst_e    (ctl.dst_e),
        .val_e    (alu.val),
        .we_m     (commit && ctl.mem_rd),
        .dst_m    (ctl.dst_m),
        .val_m    (valm),
        .peek_idx (peek_sel),
        .peek_val (peek_val),
        .sp_val   (sp_val)
    );

    seqcore_mem #(.BYTES(MEM_BYTES)) u_mem (
        .clk        (clk),
        .ld_en      (load_en),
        .ld_addr    (load_addr),
        .ld_byte    (load_byte),
        .fetch_addr (pc_q),
        .fetch_win  (fwin),
        .rd_addr    (mem_addr),
        .rd_word    (valm),
        .wr_en      (commit && ctl.mem_wr),
        .wr_addr    (mem_addr),
        .wr_word    (wdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
            st_q <= ST_RUN;
            cc_q <= '0;
        end else if (running) begin
            st_q <= next_st;
            if (commit) begin
                pc_q <= npc;
                if (ctl.set_cc) begin
                    cc_q <= alu.f;
                end
            end
        end
    end

    assign pc     = pc_q;
    assign status = st_q;
    assign flags  = cc_q;

    assert_freeze_R9: assert property (@(posedge clk) disable iff (rst)
        (!rst && st_q != ST_RUN) |=> ($stable(pc_q) && $stable(st_q) && $stable(cc_q) && $stable(sp_val)));

    assert_status_code_R9: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_RUN || st_q == ST_HALT || st_q == ST_BADADDR || st_q == ST_BADOP));

    assert_push_sp_R5: assert property (@(posedge clk) disable iff (rst)
        (commit && icode == OP_PUSH) |=> (sp_val == $past(valb) - XLEN'(WORD_B)));

    assert_call_pc_R6: assert property (@(posedge clk) disable iff (rst)
        (commit && icode == OP_CALL) |=> (pc_q == $past(valc)));

    assert_fault_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (running && next_st == ST_BADADDR) |=> ($stable(pc_q) && $stable(sp_val) && $stable(cc_q) && st_q == ST_BADADDR));

    assert_badop_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (running && next_st == ST_BADOP) |=> ($stable(pc_q) && $stable(sp_val) && $stable(cc_q) && st_q == ST_BADOP));

endmodule

// File: tb/tb_seqcore.sv
`timescale 1ns/1ps
module tb_seqcore;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_en = 1'b0;
    logic [7:0]  load_addr = '0;
    logic [7:0]  load_byte = '0;
    logic [2:0]  peek_sel = '0;
    logic [31:0] peek_val, pc;
    logic [2:0]  status, flags;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [7:0] img [256];
    int pos;

    always #2 clk = ~clk;

    seqcore dut (
        .clk       (clk),
        .rst       (rst),
        .load_en   (load_en),
        .load_addr (load_addr),
        .load_byte (load_byte),
        .peek_sel  (peek_sel),
        .peek_val  (peek_val),
        .pc        (pc),
        .status    (status),
        .flags     (flags)
    );

    // fn, a (reg 0), b (reg 1), expected reg 1, expected {z,s,o}
    localparam logic [102:0] ALU_VEC [7] = '{
        {4'd0, 32'd5,          32'd7,          32'd12,         3'b000},
        {4'd1, 32'd7,          32'd7,          32'd0,          3'b100},
        {4'd1, 32'd1,          32'd0,          32'hFFFF_FFFF,  3'b010},
        {4'd0, 32'd1,          32'h7FFF_FFFF,  32'h8000_0000,  3'b011},
        {4'd2, 32'hF0F0_F0F0,  32'h0FF0_0FF0,  32'h00F0_00F0,  3'b000},
        {4'd3, 32'hFFFF_0000,  32'hFFFF_0000,  32'd0,          3'b100},
        {4'd1, 32'd1,          32'h8000_0000,  32'h7FFF_FFFF,  3'b001}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic new_prog();
        for (int i = 0; i < 256; i++) img[i] = 8'h00;
        pos = 0;
    endtask

    task automatic emit(input logic [7:0] b);
        img[pos] = b;
        pos++;
    endtask

    task automatic emit_w(input logic [31:0] w);
        for (int k = 0; k < 4; k++) emit(w[8*k +: 8]);
    endtask

    task automatic i_irmov(input logic [3:0] rb, input logic [31:0] v);
        emit(8'h30); emit({4'hF, rb}); emit_w(v);
    endtask

    task automatic i_rr(input logic [3:0] op, input logic [3:0] fn, input logic [3:0] ra, input logic [3:0] rb);
        emit({op, fn}); emit({ra, rb});
    endtask

    task automatic i_mem(input logic [3:0] op, input logic [3:0] ra, input logic [3:0] rb, input logic [31:0] d);
        emit({op, 4'h0}); emit({ra, rb}); emit_w(d);
    endtask

    task automatic i_jmp(input logic [3:0] op, input logic [3:0] fn, input logic [31:0] dest);
        emit({op, fn}); emit_w(dest);
    endtask

    // Load the image while reset is held, then release reset at a falling edge.
    task automatic load_and_start();
        rst = 1'b1;
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            load_en   = 1'b1;
            load_addr = 8'(i);
            load_byte = img[i];
        end
        @(negedge clk);
        load_en = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_to_stop();
        int n = 0;
        while (status == 3'd1 && n < 500) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic get_reg(input int i, output logic [31:0] v);
        peek_sel = 3'(i);
        #1;
        v = peek_val;
    endtask

    initial begin
        logic [31:0] v;

        // R3 table walk (also R9 halt state and freeze)
        for (int t = 0; t < 7; t++) begin
            new_prog();
            i_irmov(4'd0, ALU_VEC[t][98:67]);
            i_irmov(4'd1, ALU_VEC[t][66:35]);
            i_rr(4'h6, ALU_VEC[t][102:99], 4'd0, 4'd1);
            emit(8'h00);
            load_and_start();
            run_to_stop();
            get_reg(1, v);
            chk("R3 result", v, ALU_VEC[t][34:3]);
            chk("R3 flags", {29'd0, flags}, {29'd0, ALU_VEC[t][2:0]});
            chk("R9 status halt", {29'd0, status}, 32'd2);
            chk("R9 pc at halt", pc, 32'h0E);
        end
        repeat (5) @(negedge clk);
        chk("R9 pc frozen", pc, 32'h0E);
        chk("R9 status frozen", {29'd0, status}, 32'd2);

        // R1 reset state, R2 one instruction per edge, R5 push timing
        new_prog();
        i_irmov(4'd4, 32'h80);
        i_irmov(4'd0, 32'h1122_3344);
        i_rr(4'hA, 4'h0, 4'd0, 4'hF);
        i_rr(4'hB, 4'h0, 4'd5, 4'hF);
        i_rr(4'h2, 4'h0, 4'd4, 4'd1);
        i_rr(4'hA, 4'h0, 4'd0, 4'hF);
        i_rr(4'hB, 4'h0, 4'd4, 4'hF);
        emit(8'h00);
        load_and_start();
        rst = 1'b1;
        @(negedge clk);
        chk("R1 pc", pc, 32'd0);
        chk("R1 status", {29'd0, status}, 32'd1);
        chk("R1 flags", {29'd0, flags}, 32'd0);
        for (int i = 0; i < 8; i++) begin
            get_reg(i, v);
            chk("R1 register zero", v, 32'd0);
        end
        rst = 1'b0;
        @(negedge clk);
        chk("R2 pc after one edge", pc, 32'h06);
        @(negedge clk);
        chk("R2 pc after two edges", pc, 32'h0C);
        @(negedge clk);
        get_reg(4, v);
        chk("R5 sp after push", v, 32'h7C);
        run_to_stop();
        get_reg(5, v);
        chk("R5 popped value", v, 32'h1122_3344);
        get_reg(1, v);
        chk("R5 sp restored", v, 32'h80);
        get_reg(4, v);
        chk("R5 pop into sp takes loaded value", v, 32'h1122_3344);

        // R4 store/load, base register none reads 0
        new_prog();
        i_irmov(4'd3, 32'h80);
        i_irmov(4'd2, 32'hCAFE_BABE);
        i_mem(4'h4, 4'd2, 4'd3, 32'd8);
        i_mem(4'h5, 4'd6, 4'd3, 32'd8);
        i_mem(4'h5, 4'd7, 4'hF, 32'h88);
        emit(8'h00);
        load_and_start();
        run_to_stop();
        get_reg(6, v);
        chk("R4 load base+disp", v, 32'hCAFE_BABE);
        get_reg(7, v);
        chk("R4 load no base", v, 32'hCAFE_BABE);

        // R6 call and return
        new_prog();
        i_irmov(4'd4, 32'h80);
        i_jmp(4'h8, 4'h0, 32'h20);
        i_irmov(4'd2, 32'h55);
        emit(8'h00);
        pos = 32'h20;
        i_irmov(4'd3, 32'h77);
        i_rr(4'h2, 4'h0, 4'd4, 4'd1);
        i_mem(4'h5, 4'd7, 4'd4, 32'd0);
        emit(8'h90);
        load_and_start();
        run_to_stop();
        get_reg(1, v);
        chk("R6 sp inside call", v, 32'h7C);
        get_reg(7, v);
        chk("R6 stored return address", v, 32'h0B);
        get_reg(3, v);
        chk("R6 callee ran", v, 32'h77);
        get_reg(2, v);
        chk("R6 returned to caller", v, 32'h55);
        get_reg(4, v);
        chk("R6 sp after return", v, 32'h80);
        chk("R6 final pc", pc, 32'h11);

        // R7 conditional jumps
        new_prog();
        i_irmov(4'd0, 32'd5);
        i_irmov(4'd1, 32'd5);
        i_rr(4'h6, 4'h1, 4'd0, 4'd1);
        i_jmp(4'h7, 4'h4, 32'h40);
        i_jmp(4'h7, 4'h3, 32'h30);
        i_irmov(4'd2, 32'd1);
        emit(8'h00);
        pos = 32'h30;
        i_irmov(4'd3, 32'd9);
        i_jmp(4'h7, 4'h0, 32'h40);
        pos = 32'h40;
        emit(8'h00);
        load_and_start();
        run_to_stop();
        chk("R7 jump path", pc, 32'h40);
        get_reg(3, v);
        chk("R7 taken target ran", v, 32'd9);
        get_reg(2, v);
        chk("R7 skipped fall-through", v, 32'd0);

        // R8 conditional moves
        new_prog();
        i_irmov(4'd0, 32'd3);
        i_irmov(4'd1, 32'd3);
        i_rr(4'h6, 4'h1, 4'd0, 4'd1);
        i_irmov(4'd2, 32'hAA);
        i_rr(4'h2, 4'h4, 4'd2, 4'd5);
        i_rr(4'h2, 4'h3, 4'd2, 4'd6);
        i_rr(4'h2, 4'h2, 4'd2, 4'd7);
        emit(8'h00);
        load_and_start();
        run_to_stop();
        get_reg(5, v);
        chk("R8 false cond no write", v, 32'd0);
        get_reg(6, v);
        chk("R8 true cond writes", v, 32'hAA);
        get_reg(7, v);
        chk("R8 false less no write", v, 32'd0);

        // R10 bad function code
        new_prog();
        i_irmov(4'd1, 32'd7);
        i_irmov(4'd0, 32'd2);
        i_rr(4'h6, 4'h5, 4'd0, 4'd1);
        load_and_start();
        run_to_stop();
        chk("R10 status", {29'd0, status}, 32'd4);
        chk("R10 pc held", pc, 32'h0C);
        get_reg(1, v);
        chk("R10 no reg update", v, 32'd7);
        chk("R10 flags untouched", {29'd0, flags}, 32'd0);

        // R10 unknown opcode
        new_prog();
        i_irmov(4'd1, 32'd7);
        emit(8'hC0);
        load_and_start();
        run_to_stop();
        chk("R10 unknown opcode status", {29'd0, status}, 32'd4);
        chk("R10 unknown opcode pc", pc, 32'h06);

        // R11 data access at the boundary
        new_prog();
        i_irmov(4'd3, 32'hFC);
        i_mem(4'h4, 4'd3, 4'd3, 32'd0);
        i_mem(4'h5, 4'd2, 4'd3, 32'd0);
        i_mem(4'h5, 4'd1, 4'd3, 32'd1);
        emit(8'h00);
        load_and_start();
        run_to_stop();
        chk("R11 status", {29'd0, status}, 32'd3);
        chk("R11 pc at fault", pc, 32'h12);
        get_reg(2, v);
        chk("R11 last word accessible", v, 32'hFC);
        get_reg(1, v);
        chk("R11 no reg update", v, 32'd0);

        // R11 fetch beyond memory
        new_prog();
        i_jmp(4'h7, 4'h0, 32'hFF);
        img[255] = 8'h30;
        load_and_start();
        run_to_stop();
        chk("R11 fetch status", {29'd0, status}, 32'd3);
        chk("R11 fetch pc", pc, 32'hFF);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule